// File: doc/BRIEF.md
# Serial Stereo Sample Frame Buffer

This block takes a two-channel serial audio stream: a bit clock, a word clock that selects the channel, and one data line. All three are sampled in the system clock domain. It assembles each 16-bit sample and joins every left/right pair into one 32-bit complex word. The left sample is the real half and the right sample is the imaginary half, so a single downstream transform can process both channels at once. Words go into a frame memory at ascending addresses. The fill level is tracked by a 16-bit counter of received samples.

When a frame of `FRAME_PAIRS` pairs is complete, the controller stops storing. It streams the frame out word by word, and a `hold` input can stall this stream. It then clears the memory for `FRAME_PAIRS` cycles before it accepts samples again. Pairs that complete while the block is streaming or clearing are discarded, and a sticky flag records the loss.

Top module: `stereo_frame_buf`

## Requirements
- R1: Data bits are taken MSB first on rising edges of `ser_bclk`. `ser_ws` low marks the left channel. The left sample is captured when `ser_ws` rises, and a pair is complete when `ser_ws` falls again after a captured left sample.
- R2: Each complete pair is written as one word with the left sample in bits [31:16] and the right sample in bits [15:0]. `wr_en` is high for one cycle per word, and `wr_addr` counts up from 0 within a frame.
- R3: Once `FRAME_PAIRS` words are stored, the frame is streamed out in ascending address order. Each word appears on `rd_data` together with its address on `rd_addr`, and `valid` is high for exactly one cycle per word.
- R4: While `hold` is high, streaming stalls. `valid` is never high in the cycle after a clock edge at which `hold` was high, and no word is lost or repeated.
- R5: `done` is a one-cycle pulse in the cycle right after the last word's `valid`, once per frame.
- R6: After streaming, the block clears memory for `FRAME_PAIRS` cycles and then stores the next pair at address 0.
- R7: A pair that completes while the block is streaming or clearing produces no write. It sets `overrun`, which stays high until reset.
- R8: While `enable` is low in the storing phase, complete pairs are ignored: no write, no count and no `overrun`.
- R9: After reset `wr_en`, `valid`, `done` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bclk | input | 1 | Serial bit clock (asynchronous) |
| ser_ws | input | 1 | Word clock, low = left channel (asynchronous) |
| ser_data | input | 1 | Serial sample data (asynchronous) |
| enable | input | 1 | Allows storing of complete pairs |
| hold | input | 1 | Stalls the frame stream |
| wr_en | output | 1 | A sample word is being stored |
| wr_addr | output | ADDR_W | Address of the stored word |
| wr_data | output | 2*SAMPLE_W | Stored word {left, right} |
| rd_addr | output | ADDR_W | Address of the word on rd_data |
| rd_data | output | 2*SAMPLE_W | Streamed frame word |
| valid | output | 1 | rd_data/rd_addr carry a word this cycle |
| done | output | 1 | Frame stream finished |
| overrun | output | 1 | Sticky: a pair was dropped |

## Verification
The bench uses a 16-pair frame. Every pair carries distinct left and right values, including all-zero, all-one and MSB-only samples. Swapped halves, a reversed bit order or an off-by-one shift would each change a stored word. One frame is streamed with `hold` raised both before the stream starts and in the middle of it, which separates a real stall from a dropped or repeated word. A pair is released inside the clearing window, and later a pair arrives after clearing has ended. Together these separate discarding with `overrun` from restarting at address 0. A burst sent with `enable` low separates ignoring pairs from flagging them as lost.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_STORE = 2'd1,
        ST_FLUSH = 2'd2,
        ST_EMPTY = 2'd3
    } sfb_state_e;

endpackage

// File: rtl/sfb_sync.sv
module sfb_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sfb_deser.sv
module sfb_deser #(
    parameter int SAMPLE_W = 16,
    localparam int PAIR_W  = 2 * SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_s,
    input  logic              ws_s,
    input  logic              sd_s,
    output logic              pair_valid,
    output logic [PAIR_W-1:0] pair_word
);

    typedef struct packed {
        logic                bclk_prev;
        logic                ws_prev;
        logic [SAMPLE_W-1:0] shreg;
        logic [SAMPLE_W-1:0] left;
        logic                left_ok;
        logic                pv;
        logic [PAIR_W-1:0]   word;
    } deser_t;

    deser_t q, d;

    always_comb begin
        d           = q;
        d.pv        = 1'b0;
        d.bclk_prev = bclk_s;
        d.ws_prev   = ws_s;
        if (bclk_s && !q.bclk_prev) begin
            d.shreg = {q.shreg[SAMPLE_W-2:0], sd_s};
        end
        if (ws_s && !q.ws_prev) begin
            d.left    = q.shreg;
            d.left_ok = 1'b1;
        end
        if (!ws_s && q.ws_prev) begin
            if (q.left_ok) begin
                d.pv   = 1'b1;
                d.word = {q.left, q.shreg};
            end
            d.left_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pair_valid = q.pv;
    assign pair_word  = q.word;

    a_r1_pair_single: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

endmodule

// File: rtl/sfb_frame_ram.sv
module sfb_frame_ram #(
    parameter int DEPTH    = 256,
    parameter int WIDTH    = 32,
    localparam int ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/stereo_frame_buf.sv
module stereo_frame_buf
    import sfb_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int FRAME_PAIRS = 256,
    parameter int CNT_W       = 16,
    localparam int PAIR_W     = 2 * SAMPLE_W,
    localparam int ADDR_W     = (FRAME_PAIRS > 1) ? $clog2(FRAME_PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bclk,
    input  logic              ser_ws,
    input  logic              ser_data,
    input  logic              enable,
    input  logic              hold,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PAIR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PAIR_W-1:0] rd_data,
    output logic              valid,
    output logic              done,
    output logic              overrun
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_PAIRS - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(2 * (FRAME_PAIRS - 1));

    // Synchronize the serial pins into the system clock
    logic [2:0] pins_s;

    sfb_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_bclk, ser_ws, ser_data}),
        .sync_o  (pins_s)
    );

    logic              pair_valid;
    logic [PAIR_W-1:0] pair_word;

    sfb_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_s     (pins_s[2]),
        .ws_s       (pins_s[1]),
        .sd_s       (pins_s[0]),
        .pair_valid (pair_valid),
        .pair_word  (pair_word)
    );

    typedef struct packed {
        sfb_state_e        state;
        logic [ADDR_W-1:0] wr_ptr;
        logic [ADDR_W-1:0] rd_ptr;
        logic [CNT_W-1:0]  count;
        logic              we;
        logic              clr;
        logic [ADDR_W-1:0] waddr;
        logic [PAIR_W-1:0] wdata;
        logic              valid;
        logic              last;
        logic [ADDR_W-1:0] raddr_out;
        logic              done;
        logic              overrun;
    } ctrl_t;

    ctrl_t             q, d;
    logic              ram_re;
    logic [ADDR_W-1:0] ram_raddr;

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        d.clr     = 1'b0;
        d.valid   = 1'b0;
        d.last    = 1'b0;
        d.done    = q.valid && q.last;
        ram_re    = 1'b0;
        ram_raddr = q.rd_ptr;

        if (pair_valid && (q.state != ST_STORE)) begin
            d.overrun = 1'b1;
        end

        case (q.state)
            ST_RESET: begin
                d.state  = ST_STORE;
                d.wr_ptr = '0;
                d.rd_ptr = '0;
                d.count  = '0;
            end
            ST_STORE: begin
                if (pair_valid && enable) begin
                    d.we    = 1'b1;
                    d.waddr = q.wr_ptr;
                    d.wdata = pair_word;
                    if (q.count == FULL_CNT) begin
                        d.state  = ST_FLUSH;
                        d.wr_ptr = '0;
                        d.rd_ptr = '0;
                        d.count  = '0;
                    end else begin
                        d.wr_ptr = q.wr_ptr + 1'b1;
                        d.count  = q.count + CNT_W'(2);
                    end
                end
            end
            ST_FLUSH: begin
                if (!hold) begin
                    ram_re      = 1'b1;
                    d.valid     = 1'b1;
                    d.raddr_out = q.rd_ptr;
                    if (q.rd_ptr == LAST_ADDR) begin
                        d.last   = 1'b1;
                        d.state  = ST_EMPTY;
                        d.rd_ptr = '0;
                    end else begin
                        d.rd_ptr = q.rd_ptr + 1'b1;
                    end
                end
            end
            ST_EMPTY: begin
                d.we    = 1'b1;
                d.clr   = 1'b1;
                d.waddr = q.rd_ptr;
                d.wdata = '0;
                if (q.rd_ptr == LAST_ADDR) begin
                    d.state  = ST_STORE;
                    d.rd_ptr = '0;
                end else begin
                    d.rd_ptr = q.rd_ptr + 1'b1;
                end
            end
            default: d.state = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_RESET;
        end else begin
            q <= d;
        end
    end

    sfb_frame_ram #(.DEPTH(FRAME_PAIRS), .WIDTH(PAIR_W)) u_ram (
        .clk   (clk),
        .we    (q.we),
        .waddr (q.waddr),
        .wdata (q.wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (rd_data)
    );

    assign wr_en   = q.we && !q.clr;
    assign wr_addr = q.waddr;
    assign wr_data = q.wdata;
    assign rd_addr = q.raddr_out;
    assign valid   = q.valid;
    assign done    = q.done;
    assign overrun = q.overrun;

    a_r3_addr_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

    a_r4_hold_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !$past(hold));

    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(valid) && !valid));

    a_r6_done_in_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (q.state == ST_EMPTY));

    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overrun) |-> overrun);

    a_r8_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(enable));

endmodule

// File: tb/stereo_frame_buf_tb.sv
`timescale 1ns/1ps
module stereo_frame_buf_tb;

    localparam int P  = 16;
    localparam int AW = 4;
    localparam int H  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_bclk = 1'b0, ser_ws = 1'b0, ser_data = 1'b0;
    logic enable = 1'b1, hold = 1'b0;
    logic          wr_en, valid, done, overrun;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [31:0]   wr_data, rd_data;

    always #2 clk = ~clk;

    stereo_frame_buf #(.SAMPLE_W(16), .FRAME_PAIRS(P), .CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_bclk(ser_bclk), .ser_ws(ser_ws),
        .ser_data(ser_data), .enable(enable), .hold(hold), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .valid(valid), .done(done), .overrun(overrun)
    );

    int checks = 0, errors = 0, cyc = 0;
    int nw = 0, nv = 0, nd = 0;
    logic [31:0]   wlog_d [64];
    logic [AW-1:0] wlog_a [64];
    logic [31:0]   rlog_d [64];
    logic [AW-1:0] rlog_a [64];
    int            rlog_c [64];
    int            done_c [4];
    logic          hold_prev = 1'b0;
    bit            finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (wr_en && nw < 64) begin
                wlog_d[nw] = wr_data; wlog_a[nw] = wr_addr; nw++;
            end
            if (valid) begin
                chk(!hold_prev, "R4 valid after held edge", 32'(valid), 32'h0);
                if (nv < 64) begin
                    rlog_d[nv] = rd_data; rlog_a[nv] = rd_addr; rlog_c[nv] = cyc; nv++;
                end
            end
            if (done && nd < 4) begin
                done_c[nd] = cyc; nd++;
            end
        end
        hold_prev = hold;
    end

    function automatic logic [15:0] smp(input int ph, input int k, input bit right);
        logic [15:0] v;
        if (k == 0) v = right ? 16'hFFFF : 16'h0000;
        else if (k == 1) v = right ? 16'h0001 : 16'h8000;
        else v = 16'((k * 16'h1357) ^ (ph * 16'h2468) ^ (right ? 16'hA5C3 : 16'h3C5A));
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_half(input logic [15:0] s, input logic lvl);
        for (int i = 15; i >= 0; i--) begin
            if (i == 15) ser_ws = lvl;
            ser_data = s[i];
            tick(H);
            ser_bclk = 1'b1;
            tick(H);
            ser_bclk = 1'b0;
        end
    endtask

    task automatic send_pair(input int ph, input int k);
        send_half(smp(ph, k, 1'b0), 1'b0);
        send_half(smp(ph, k, 1'b1), 1'b1);
    endtask

    task automatic wait_done(input int target);
        for (int g = 0; g < 5000 && nd < target; g++) tick(1);
    endtask

    initial begin
        int snap;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R9 reset state
        chk(!wr_en, "R9 wr_en after reset", 32'(wr_en), 0);
        chk(!valid, "R9 valid after reset", 32'(valid), 0);
        chk(!done, "R9 done after reset", 32'(done), 0);
        chk(!overrun, "R9 overrun after reset", 32'(overrun), 0);

        // R8: pairs with enable low are ignored
        enable = 1'b0;
        send_pair(9, 3);
        send_pair(9, 4);
        send_half(16'h1234, 1'b0);
        tick(20);
        chk(nw == 0, "R8 no write while disabled", 32'(nw), 0);
        chk(!overrun, "R8 no overrun while disabled", 32'(overrun), 0);
        enable = 1'b1;
        tick(2 * H * 16);

        // Phase A: fill a frame with hold already high
        hold = 1'b1;
        for (int k = 0; k < P; k++) send_pair(1, k);
        send_half(16'h7777, 1'b0);
        send_half(16'h8888, 1'b1);
        chk(nw == P, "R2 write count frame 1", 32'(nw), 32'(P));
        for (int k = 0; k < P; k++) begin
            chk(wlog_d[k] == {smp(1, k, 1'b0), smp(1, k, 1'b1)}, "R1 R2 stored word",
                wlog_d[k], {smp(1, k, 1'b0), smp(1, k, 1'b1)});
            chk(wlog_a[k] == AW'(k), "R2 write address", 32'(wlog_a[k]), 32'(k));
        end
        chk(nv == 0, "R4 no stream while held", 32'(nv), 0);
        hold = 1'b0;
        tick(5);
        hold = 1'b1;
        tick(2);
        snap = nv;
        tick(20);
        chk(nv == snap, "R4 stall mid stream", 32'(nv), 32'(snap));
        hold = 1'b0;
        wait_done(1);
        // release the pending pair inside the clearing window
        ser_ws = 1'b0;
        tick(P + 30);
        chk(overrun, "R7 overrun after drop in clear", 32'(overrun), 1);
        chk(nw == P, "R7 dropped pair not written", 32'(nw), 32'(P));
        chk(nv == P, "R3 one valid per word", 32'(nv), 32'(P));
        for (int k = 0; k < P && k < nv; k++) begin
            chk(rlog_d[k] == {smp(1, k, 1'b0), smp(1, k, 1'b1)}, "R3 streamed word",
                rlog_d[k], {smp(1, k, 1'b0), smp(1, k, 1'b1)});
            chk(rlog_a[k] == AW'(k), "R3 streamed address", 32'(rlog_a[k]), 32'(k));
        end
        chk(nd == 1, "R5 one done frame 1", 32'(nd), 1);
        if (nv >= P && nd >= 1)
            chk(done_c[0] == rlog_c[P-1] + 1, "R5 done after last valid",
                32'(done_c[0]), 32'(rlog_c[P-1] + 1));

        // Phase C: continuous stream, one extra pair lands after clearing
        for (int k = 0; k <= P; k++) send_pair(2, k);
        ser_ws = 1'b0;
        tick(2 * H * 16);
        chk(nw == 2 * P + 1, "R6 writes frame 2 plus restart", 32'(nw), 32'(2 * P + 1));
        for (int k = 0; k < P && P + k < nw; k++)
            chk(rlog_d[P+k] == {smp(2, k, 1'b0), smp(2, k, 1'b1)}, "R3 frame 2 word",
                rlog_d[P+k], {smp(2, k, 1'b0), smp(2, k, 1'b1)});
        if (nw > 2 * P) begin
            chk(wlog_a[2*P] == '0, "R6 restart at address 0", 32'(wlog_a[2*P]), 0);
            chk(wlog_d[2*P] == {smp(2, P, 1'b0), smp(2, P, 1'b1)}, "R6 restart word",
                wlog_d[2*P], {smp(2, P, 1'b0), smp(2, P, 1'b1)});
        end
        chk(nd == 2, "R5 done count", 32'(nd), 2);
        chk(overrun, "R7 overrun stays set", 32'(overrun), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule